// File: doc/BRIEF.md
# Pipelined Instruction Fetch with Delay-Slot Redirect

The block generates a stream of sequential instruction addresses and fetches them from an instruction memory. Several requests may be in flight at once. The memory answers them strictly in the order they were issued, and each answer may take a variable number of cycles. The block remembers the address of every pending request and pairs each returned word with its address. The pairs are delivered through an output queue that has a ready/valid handshake.

A redirect gives two addresses: where the new stream starts, and a delay-slot address that must be fetched before that stream. When a redirect arrives, the block does the following:

- It empties the address queue and the output queue.
- It stops issuing requests and waits until every earlier request has been answered. Those answers are thrown away.
- It issues the delay-slot fetch on its own.
- It then carries on sequentially from the new stream address.

Top module: `sfetch_top`

## Requirements
- R1: While reset is asserted, no request and no output is valid. The first request after reset carries address RESET_PC (default 0).
- R2: Without a redirect, delivered addresses increase by 4 from one output to the next.
- R3: Each output pairs a returned word with the address of the request it answers, in issue order. No word is lost or duplicated.
- R4: At most WAIT_DEPTH (default 4) requests are pending. No request is issued while that many are pending.
- R5: No request is issued in a redirect cycle, and the output is not valid in the cycle that follows.
- R6: Words returned for requests issued before a redirect never reach the output.
- R7: After a redirect, no request is issued until every earlier request has been answered.
- R8: The first request after a redirect carries the delay-slot address. The next one carries the new stream address, and later outputs follow that address in steps of 4.
- R9: A redirect that arrives while the block is still draining replaces both stored addresses. Only the newest delay-slot and stream addresses are fetched.
- R10: While the output is valid and not accepted, and there is no redirect, the output stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Redirect command |
| redir_target | input | AW | New stream start address |
| redir_slot | input | AW | Delay-slot address fetched first |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_addr | output | AW | Fetch request address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Returned word valid (in request order) |
| mem_rsp_data | input | DW | Returned instruction word |
| out_valid | output | 1 | Output pair valid |
| out_pc | output | AW | Address of the delivered word |
| out_instr | output | DW | Delivered instruction word |
| out_ready | input | 1 | Consumer accepts the output |

## Verification
The request signals respond combinationally to the redirect and ready inputs in the same cycle. A returned word reaches the output one cycle after it arrives. After reset the address queue fills one cycle after release, and the first request appears in the next cycle. A redirect makes the output invalid one cycle later.

The bench sets its inputs just after the falling edge and samples the outputs one time unit later. Every handshake is scored against the inputs applied for the same upcoming rising edge. The memory model checks the ordering of post-redirect requests at the moment it accepts them, using its own count of pending requests. The redirect-cycle flush is checked at the following falling edge.

// File: rtl/sfetch_pkg.sv
package sfetch_pkg;
   typedef enum logic [1:0] {
      FS_RUN   = 2'd0,
      FS_DRAIN = 2'd1,
      FS_SLOT  = 2'd2
   } fstate_t;
endpackage

// File: rtl/sfetch_fifo.sv
module sfetch_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sfetch_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] rp, wp;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + PW'(1);
         if (pop)  rp <= rp + PW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) store[wp] <= din;
   end

   assign dout  = store[rp];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/sfetch_pcgen.sv
module sfetch_pcgen #(
   parameter int          AW       = 32,
   parameter int          DEPTH    = 4,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          goto_valid,
   input  logic [AW-1:0] goto_addr,
   input  logic          pop,
   output logic [AW-1:0] head,
   output logic          empty
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [AW-1:0] pc_q;
   logic          full;
   logic          push;
   logic [CW-1:0] cnt;

   assign push = !goto_valid && !full;

   always_ff @(posedge clk) begin
      if (!rst_n)          pc_q <= AW'(RESET_PC);
      else if (goto_valid) pc_q <= goto_addr;
      else if (push)       pc_q <= pc_q + AW'(4);
   end

   sfetch_fifo #(.W(AW), .DEPTH(DEPTH)) u_pcq (
      .clk(clk), .rst_n(rst_n), .clr(goto_valid),
      .push(push), .din(pc_q), .pop(pop),
      .dout(head), .empty(empty), .full(full), .count(cnt)
   );
endmodule

// File: rtl/sfetch_ctrl.sv
module sfetch_ctrl
   import sfetch_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int WAIT_DEPTH = 4,
   parameter int OUT_DEPTH  = 8,
   localparam int WCW       = $clog2(WAIT_DEPTH + 1),
   localparam int OCW       = $clog2(OUT_DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           redir_valid,
   input  logic [AW-1:0]  redir_slot,
   input  logic [AW-1:0]  pcq_head,
   input  logic           pcq_empty,
   output logic           pcq_pop,
   output logic           mem_req_valid,
   output logic [AW-1:0]  mem_req_addr,
   input  logic           mem_req_ready,
   input  logic           mem_rsp_valid,
   input  logic [DW-1:0]  mem_rsp_data,
   input  logic [OCW-1:0] out_cnt,
   output logic           out_push,
   output logic [AW+DW-1:0] out_din,
   output logic [WCW-1:0] wait_cnt,
   output fstate_t        fstate
);
   fstate_t       st_q, st_d;
   logic [AW-1:0] slot_q;
   logic [AW-1:0] wait_head;
   logic          wait_empty, wait_full;
   logic          credit, fire;

   assign credit = (int'(out_cnt) + int'(wait_cnt)) < OUT_DEPTH;

   always_comb begin
      mem_req_valid = !redir_valid && !wait_full && credit &&
                      ((st_q == FS_RUN && !pcq_empty) || st_q == FS_SLOT);
      mem_req_addr  = (st_q == FS_SLOT) ? slot_q : pcq_head;
   end

   assign fire    = mem_req_valid && mem_req_ready;
   assign pcq_pop = fire && (st_q == FS_RUN);

   always_comb begin
      st_d = st_q;
      if (redir_valid) st_d = FS_DRAIN;
      else begin
         case (st_q)
            FS_DRAIN: if (wait_empty) st_d = FS_SLOT;
            FS_SLOT:  if (fire)       st_d = FS_RUN;
            default:  st_d = FS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= FS_RUN;
         slot_q <= '0;
      end else begin
         st_q <= st_d;
         if (redir_valid) slot_q <= redir_slot;
      end
   end

   sfetch_fifo #(.W(AW), .DEPTH(WAIT_DEPTH)) u_waitq (
      .clk(clk), .rst_n(rst_n), .clr(1'b0),
      .push(fire), .din(mem_req_addr), .pop(mem_rsp_valid),
      .dout(wait_head), .empty(wait_empty), .full(wait_full), .count(wait_cnt)
   );

   assign out_push = mem_rsp_valid && !redir_valid && (st_q != FS_DRAIN);
   assign out_din  = {wait_head, mem_rsp_data};
   assign fstate   = st_q;
endmodule

// File: rtl/sfetch_top.sv
module sfetch_top
   import sfetch_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          DW         = 32,
   parameter int          PCQ_DEPTH  = 4,
   parameter int          WAIT_DEPTH = 4,
   parameter int          OUT_DEPTH  = 8,
   parameter logic [31:0] RESET_PC   = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          redir_valid,
   input  logic [AW-1:0] redir_target,
   input  logic [AW-1:0] redir_slot,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          out_valid,
   output logic [AW-1:0] out_pc,
   output logic [DW-1:0] out_instr,
   input  logic          out_ready
);
   localparam int WCW = $clog2(WAIT_DEPTH + 1);
   localparam int OCW = $clog2(OUT_DEPTH + 1);

   generate
      if (AW < 3 || AW > 32) begin : g_bad_aw
         $error("sfetch_top: AW must lie in 3..32");
      end
      if (OUT_DEPTH < WAIT_DEPTH) begin : g_bad_out
         $error("sfetch_top: OUT_DEPTH must cover WAIT_DEPTH");
      end
   endgenerate

   logic [AW-1:0]    pcq_head;
   logic             pcq_empty, pcq_pop;
   logic             out_push, out_empty, out_full;
   logic [AW+DW-1:0] out_din, out_dout;
   logic [OCW-1:0]   out_cnt;
   logic [WCW-1:0]   wait_cnt;
   fstate_t          fstate;

   sfetch_pcgen #(.AW(AW), .DEPTH(PCQ_DEPTH), .RESET_PC(RESET_PC)) u_pcgen (
      .clk(clk), .rst_n(rst_n), .goto_valid(redir_valid), .goto_addr(redir_target),
      .pop(pcq_pop), .head(pcq_head), .empty(pcq_empty)
   );

   sfetch_ctrl #(.AW(AW), .DW(DW), .WAIT_DEPTH(WAIT_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_slot(redir_slot),
      .pcq_head(pcq_head), .pcq_empty(pcq_empty), .pcq_pop(pcq_pop),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .out_cnt(out_cnt), .out_push(out_push),
      .out_din(out_din), .wait_cnt(wait_cnt), .fstate(fstate)
   );

   sfetch_fifo #(.W(AW + DW), .DEPTH(OUT_DEPTH)) u_outq (
      .clk(clk), .rst_n(rst_n), .clr(redir_valid),
      .push(out_push), .din(out_din), .pop(out_valid && out_ready),
      .dout(out_dout), .empty(out_empty), .full(out_full), .count(out_cnt)
   );

   assign out_valid = !out_empty;
   assign out_pc    = out_dout[AW+DW-1:DW];
   assign out_instr = out_dout[DW-1:0];
endmodule

// File: rtl/sfetch_chk.sv
module sfetch_chk
   import sfetch_pkg::*;
#(
   parameter int AW         = 32,
   parameter int WAIT_DEPTH = 4,
   parameter int CW         = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          redir_valid,
   input logic          mem_req_valid,
   input logic          mem_rsp_valid,
   input logic          out_valid,
   input logic          out_ready,
   input logic [AW-1:0] out_pc,
   input logic [CW-1:0] wait_cnt,
   input fstate_t       fstate
);
   a_r5_quiet_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> !mem_req_valid);

   a_r5_outq_flushed: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !out_valid);

   a_r4_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_cnt == CW'(WAIT_DEPTH)) |-> !mem_req_valid);

   a_r7_drain_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      (fstate == FS_DRAIN) |-> !mem_req_valid);

   a_r8_slot_follows_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (fstate == FS_DRAIN && wait_cnt == '0 && !redir_valid) |=> (fstate == FS_SLOT));

   a_r3_rsp_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (wait_cnt != '0));

   a_r10_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !redir_valid) |=> (out_valid && $stable(out_pc)));
endmodule

bind sfetch_top sfetch_chk #(.AW(AW), .WAIT_DEPTH(WAIT_DEPTH), .CW(WCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .mem_req_valid(mem_req_valid),
   .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid), .out_ready(out_ready),
   .out_pc(out_pc), .wait_cnt(wait_cnt), .fstate(fstate)
);

// File: tb/sfetch_top_tb.sv
module sfetch_top_tb;
   localparam int WAIT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redir_valid = 1'b0;
   logic [31:0] redir_target = '0, redir_slot = '0;
   logic        mem_req_valid, mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        out_valid, out_ready = 1'b0;
   logic [31:0] out_pc, out_instr;

   always #4 clk = ~clk;

   sfetch_top u_dut (.*);

   int errs = 0, checks = 0, cyc = 0, outputs = 0;
   logic [31:0] rq_addr[$];
   int          rq_due[$];
   int          lat_max = 5;
   int          ready_mode = 0;
   logic        exp_pend = 1'b0;
   logic [31:0] exp_slot = '0, exp_next = '0;
   logic        watch = 1'b0, watch_ph = 1'b0, first_req = 1'b1;
   logic [31:0] w_slot = '0, w_tgt = '0;
   logic        prev_hold = 1'b0, prev_redir = 1'b0;
   logic [31:0] prev_pc = '0;
   string       tag = "R2/R3";
   int          after_b = 0;

   function automatic logic [31:0] word_of(logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input bit do_redir, input logic [31:0] tgt, input logic [31:0] slt);
      @(negedge clk);
      if (rq_addr.size() > 0 && rq_due[0] <= cyc) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = word_of(rq_addr.pop_front());
         void'(rq_due.pop_front());
      end else begin
         mem_rsp_valid = 1'b0;
      end
      mem_req_ready = ($urandom % 4) != 0;
      out_ready     = do_redir ? 1'b0 : (ready_mode == 1 ? 1'b0 : (($urandom % 3) != 0));
      redir_valid   = do_redir;
      redir_target  = tgt;
      redir_slot    = slt;
      #1;
      if (prev_redir) chk(!out_valid, "R5 out flushed", {31'b0, out_valid}, 32'h0);
      if (prev_hold)  chk(out_valid && out_pc == prev_pc, "R10 hold", out_pc, prev_pc);
      if (do_redir)   chk(!mem_req_valid, "R5 no req", {31'b0, mem_req_valid}, 32'h0);
      if (mem_req_valid && mem_req_ready) begin
         chk(rq_addr.size() < WAIT, "R4 pending limit", rq_addr.size(), WAIT - 1);
         if (first_req) begin
            chk(mem_req_addr == 32'h0, "R1 first addr", mem_req_addr, 32'h0);
            first_req = 1'b0;
         end
         if (watch && !watch_ph) begin
            chk(rq_addr.size() == 0, "R7 drained", rq_addr.size(), 32'h0);
            chk(mem_req_addr == w_slot, "R8 slot first", mem_req_addr, w_slot);
            watch_ph = 1'b1;
         end else if (watch) begin
            chk(mem_req_addr == w_tgt, "R8 target next", mem_req_addr, w_tgt);
            watch = 1'b0;
         end
         rq_addr.push_back(mem_req_addr);
         rq_due.push_back(cyc + 1 + int'($urandom % lat_max));
      end
      if (out_valid && out_ready) begin
         logic [31:0] e;
         e = exp_pend ? exp_slot : exp_next;
         if (exp_pend) exp_pend = 1'b0; else exp_next = exp_next + 4;
         chk(out_pc == e, {tag, " R6 pc"}, out_pc, e);
         chk(out_instr == word_of(out_pc), {tag, " instr"}, out_instr, word_of(out_pc));
         outputs++;
         after_b++;
      end
      if (do_redir) begin
         exp_pend = 1'b1; exp_slot = slt; exp_next = tgt;
         watch = 1'b1; watch_ph = 1'b0; w_slot = slt; w_tgt = tgt;
      end
      prev_redir = do_redir;
      prev_hold  = out_valid && !out_ready && !do_redir;
      prev_pc    = out_pc;
      @(posedge clk);
      cyc++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!mem_req_valid, "R1 reset req", {31'b0, mem_req_valid}, 32'h0);
      chk(!out_valid, "R1 reset out", {31'b0, out_valid}, 32'h0);
      rst_n = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         bit r;
         r = ($urandom % 60) == 0;
         step(r, $urandom & 32'h0000_FFFC, $urandom & 32'h0000_FFFC);
      end
      tag = "R9";
      lat_max = 12;
      for (int i = 0; i < 20; i++) step(1'b0, '0, '0);
      step(1'b1, 32'h0000_1000, 32'h0000_2000);
      step(1'b0, '0, '0);
      step(1'b1, 32'h0000_3000, 32'h0000_4000);
      after_b = 0;
      for (int i = 0; i < 80; i++) step(1'b0, '0, '0);
      chk(after_b >= 2, "R9 progress", after_b, 2);
      tag = "R10";
      lat_max = 3;
      ready_mode = 1;
      for (int i = 0; i < 30; i++) step(1'b0, '0, '0);
      ready_mode = 0;
      for (int i = 0; i < 40; i++) step(1'b0, '0, '0);
      chk(outputs > 500, "R2 progress", outputs, 500);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule